// File: doc/BRIEF.md
# Staged RAM Address Pointer

This block holds the address that a host uses to reach a 2K-byte buffer RAM through an 8-bit register bus. The host fills the pointer in two writes. First it writes the upper byte, which lands in a staging register and leaves the live address unchanged. Then it writes the lower byte, and that write moves the full 11-bit address into the active pointer in one step. After that, every access on the data port moves the pointer forward. In byte mode the step is one byte. In 16-bit mode the step is two bytes. The pointer wraps at the top of the 2K space.

Two control bits sit beside the address bits. Bit 3 of the upper byte enables DMA. When it is set, committing the lower byte raises a DMA request, which stays high until the acknowledge input arrives or the next commit happens. Bit 0 of the lower byte is a byte-swap flag. In 16-bit mode, address bit 0 is not used as an address, so the block drives it as zero and presents the flag on the swap output. The DMA request comes from a two-state machine. The states are DMA_IDLE and DMA_ARMED. The transitions are *arm* (a commit with DMA enabled: DMA_IDLE or DMA_ARMED to DMA_ARMED), *drop on reload* (a commit with DMA disabled: to DMA_IDLE) and *drop on ack* (acknowledge with no commit: DMA_ARMED to DMA_IDLE).

Top module: `bufptr_ctrl`

## Requirements
- R1: After reset, `ram_addr`, `dma_req`, `swap` and `rd_data` are all zero, and the staging register reads back as zero.
- R2: A write with `sel`=1 (upper byte) changes only the staging register. `ram_addr` keeps its previous value.
- R3: A write with `sel`=0 (lower byte) loads the active pointer with {staging bits 2:0, written byte}. The new value appears on `ram_addr` in the cycle after the write edge.
- R4: In byte mode (`mode16`=0), each `data_stb` cycle adds one to the pointer, and 0x7FF wraps to 0x000.
- R5: In 16-bit mode (`mode16`=1), `ram_addr` bit 0 is 0 and `swap` equals pointer bit 0, which is the written bit 0 of the lower byte. Each `data_stb` adds two to pointer bits 10:1 and leaves bit 0 unchanged. The pointer wraps from 0x7FE or 0x7FF back to the bottom.
- R6: In byte mode, `swap` is 0 and `ram_addr` carries the full pointer, including bit 0.
- R7: A lower-byte write while staging bit 3 is 1 raises `dma_req` in the next cycle. A lower-byte write while staging bit 3 is 0 leaves `dma_req` at 0.
- R8: `dma_ack` clears `dma_req` in the next cycle. A lower-byte write in the same cycle as `dma_ack` takes priority, so the new enable bit decides `dma_req`. A reload with the enable bit at 0 also drops the request.
- R9: `rd_en` updates `rd_data` at the next edge. With `sel`=1, `rd_data` gets the staging byte. With `sel`=0, it gets the low 8 bits of the active pointer as they stood before that edge. When `rd_en` is low, `rd_data` holds its value.
- R10: If a lower-byte write and a `data_stb` fall in the same cycle, the write wins and no increment takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| sel | input | 1 | Register select: 1 = upper byte, 0 = lower byte |
| wr_data | input | 8 | Write data |
| mode16 | input | 1 | 16-bit access mode |
| data_stb | input | 1 | Data-port access; advances the pointer |
| dma_ack | input | 1 | DMA acknowledge |
| rd_data | output | 8 | Registered read-back data |
| ram_addr | output | 11 | Active RAM address |
| dma_req | output | 1 | DMA request |
| swap | output | 1 | Byte-swap control (16-bit mode only) |

## Verification
The pointer, the staging byte, `dma_req` and `rd_data` are registered, so each of them changes exactly one edge after the stimulus that causes it. `ram_addr` and `swap` also depend on `mode16` through logic with no register in the path, so they follow a mode change within the same cycle. The bench drives inputs on the falling edge and advances its reference model at the rising edge. It then compares all four outputs one time unit later, which is after the registers have settled and before the next input change.

// File: rtl/bufptr_pkg.sv
package bufptr_pkg;
    typedef enum logic {
        DMA_IDLE  = 1'b0,
        DMA_ARMED = 1'b1
    } dma_state_e;

    localparam logic SEL_LO = 1'b0;
    localparam logic SEL_HI = 1'b1;
endpackage

// File: rtl/bufptr_stage.sv
module bufptr_stage #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= din;
    end
endmodule

// File: rtl/bufptr_count.sv
module bufptr_count #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    input  logic              wide,
    output logic [ADDR_W-1:0] ptr
);
    logic [ADDR_W-1:0] stride;

    always_comb stride = wide ? ADDR_W'(2) : ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (load) ptr <= load_val;
        else if (step) ptr <= ptr + stride;
    end
endmodule

// File: rtl/bufptr_dma_fsm.sv
module bufptr_dma_fsm
    import bufptr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    input  logic enable,
    input  logic ack,
    output logic req
);
    dma_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DMA_IDLE: begin
                if (reload && enable) state_d = DMA_ARMED;
            end
            DMA_ARMED: begin
                if (reload)   state_d = enable ? DMA_ARMED : DMA_IDLE;
                else if (ack) state_d = DMA_IDLE;
            end
            default: state_d = DMA_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DMA_IDLE;
        else        state_q <= state_d;
    end

    always_comb req = (state_q == DMA_ARMED);
endmodule

// File: rtl/bufptr_ctrl.sv
module bufptr_ctrl
    import bufptr_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int DATA_W  = 8,
    parameter int DMA_BIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mode16,
    input  logic              data_stb,
    input  logic              dma_ack,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              dma_req,
    output logic              swap
);
    localparam int HI_W = ADDR_W - DATA_W;

    logic              wr_hi, wr_lo;
    logic [DATA_W-1:0] stage_q;
    logic [ADDR_W-1:0] ptr_q;

    always_comb begin
        wr_hi = wr_en && (sel == SEL_HI);
        wr_lo = wr_en && (sel == SEL_LO);
    end

    bufptr_stage #(.DATA_W(DATA_W)) stage_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wr_hi),
        .din   (wr_data),
        .q     (stage_q)
    );

    bufptr_count #(.ADDR_W(ADDR_W)) count_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_lo),
        .load_val ({stage_q[HI_W-1:0], wr_data}),
        .step     (data_stb),
        .wide     (mode16),
        .ptr      (ptr_q)
    );

    bufptr_dma_fsm dma_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (wr_lo),
        .enable (stage_q[DMA_BIT]),
        .ack    (dma_ack),
        .req    (dma_req)
    );

    always_comb begin
        ram_addr = ptr_q;
        swap     = 1'b0;
        if (mode16) begin
            ram_addr[0] = 1'b0;
            swap        = ptr_q[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= (sel == SEL_HI) ? stage_q : ptr_q[DATA_W-1:0];
    end
endmodule

// File: rtl/bufptr_ctrl_chk.sv
module bufptr_ctrl_chk #(
    parameter int ADDR_W  = 11,
    parameter int DATA_W  = 8,
    parameter int DMA_BIT = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              sel,
    input logic [DATA_W-1:0] wr_data,
    input logic              mode16,
    input logic              data_stb,
    input logic              dma_ack,
    input logic [DATA_W-1:0] stage_q,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              dma_req,
    input logic              swap
);
    localparam int HI_W = ADDR_W - DATA_W;

    // R2
    hi_write_holds_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel && !data_stb && !mode16) |=> (mode16 || $stable(ram_addr)));

    // R3
    lo_write_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel && !mode16) |=>
        (mode16 || ram_addr == {$past(stage_q[HI_W-1:0]), $past(wr_data)}));

    // R5
    wide_addr_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode16 |-> !ram_addr[0]);

    // R6
    byte_no_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode16 |-> !swap);

    // R7
    no_req_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel && !stage_q[DMA_BIT]) |=> !dma_req);

    // R8
    ack_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack && !(wr_en && !sel)) |=> !dma_req);
endmodule

bind bufptr_ctrl bufptr_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DMA_BIT(DMA_BIT)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .sel      (sel),
    .wr_data  (wr_data),
    .mode16   (mode16),
    .data_stb (data_stb),
    .dma_ack  (dma_ack),
    .stage_q  (stage_q),
    .ram_addr (ram_addr),
    .dma_req  (dma_req),
    .swap     (swap)
);

// File: tb/bufptr_ctrl_tb_top.sv
module bufptr_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       mode16 = 1'b0, data_stb = 1'b0, dma_ack = 1'b0;
    logic [7:0] rd_data;
    logic [10:0] ram_addr;
    logic       dma_req, swap;

    int total = 0;
    int bad = 0;
    int m_ptr = 0, m_hi = 0, m_req = 0, m_rd = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bufptr_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .sel(sel),
        .wr_data(wr_data), .mode16(mode16), .data_stb(data_stb), .dma_ack(dma_ack),
        .rd_data(rd_data), .ram_addr(ram_addr), .dma_req(dma_req), .swap(swap)
    );

    task automatic compare(input string tag);
        int ea, es;
        ea = mode16 ? (m_ptr & 'h7FE) : m_ptr;
        es = mode16 ? (m_ptr & 1) : 0;
        total++;
        if (int'(ram_addr) != ea || int'(swap) != es ||
            int'(dma_req) != m_req || int'(rd_data) != m_rd) begin
            bad++;
            $display("FAIL %s: addr=%h swap=%0d req=%0d rd=%h expected addr=%h swap=%0d req=%0d rd=%h",
                     tag, ram_addr, swap, dma_req, rd_data, ea, es, m_req, m_rd);
        end
    endtask

    task automatic cyc(input bit w, input bit r, input bit s, input int d,
                       input bit m16, input bit stb, input bit ack, input string tag);
        @(negedge clk);
        wr_en = w; rd_en = r; sel = s; wr_data = 8'(d);
        mode16 = m16; data_stb = stb; dma_ack = ack;
        @(posedge clk);
        if (r) m_rd = s ? m_hi : (m_ptr & 'hFF);
        if (w && !s) begin
            m_ptr = ((m_hi & 7) << 8) | (d & 'hFF);
            m_req = (m_hi >> 3) & 1;
        end else begin
            if (stb) m_ptr = (m_ptr + (m16 ? 2 : 1)) & 'h7FF;
            if (ack) m_req = 0;
        end
        if (w && s) m_hi = d & 'hFF;
        #1;
        compare(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 compare("R1 reset");
        @(negedge clk) rst_n = 1'b1;
        cyc(0, 1, 1, 0, 0, 0, 0, "R1 staging readback");
        // R2 upper byte alone, R9 read back
        cyc(1, 0, 1, 'h05, 0, 0, 0, "R2");
        cyc(0, 1, 1, 0, 0, 0, 0, "R9 hi read");
        cyc(0, 0, 0, 0, 0, 0, 0, "R9 hold");
        // R3 commit
        cyc(1, 0, 0, 'h34, 0, 0, 0, "R3");
        // R4 byte stepping
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 1, 0, "R4 step");
        cyc(0, 1, 0, 0, 0, 0, 0, "R9 lo read");
        cyc(1, 0, 1, 'h07, 0, 0, 0, "R2 hi 07");
        cyc(1, 0, 0, 'hFE, 0, 0, 0, "R3 7FE");
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 1, 0, "R4 wrap");
        // R5 16-bit mode
        cyc(1, 0, 1, 'h02, 1, 0, 0, "R5 hi");
        cyc(1, 0, 0, 'h11, 1, 0, 0, "R5 commit swap");
        for (int i = 0; i < 2; i++) cyc(0, 0, 0, 0, 1, 1, 0, "R5 step2");
        cyc(0, 1, 0, 0, 1, 0, 0, "R9 lo read wide");
        cyc(1, 0, 1, 'h07, 1, 0, 0, "R5 hi 07");
        cyc(1, 0, 0, 'hFF, 1, 0, 0, "R5 7FF");
        cyc(0, 0, 0, 0, 1, 1, 0, "R5 wrap");
        cyc(0, 0, 0, 0, 0, 0, 0, "R6 byte mode swap off");
        cyc(0, 0, 0, 0, 0, 1, 0, "R6 byte step");
        // R7 DMA enable
        cyc(1, 0, 1, 'h08, 0, 0, 0, "R7 hi en");
        cyc(1, 0, 0, 'h00, 0, 0, 0, "R7 arm");
        cyc(0, 0, 0, 0, 0, 1, 0, "R7 hold");
        cyc(0, 0, 0, 0, 0, 0, 1, "R8 ack");
        cyc(1, 0, 0, 'h10, 0, 0, 0, "R7 rearm");
        cyc(1, 0, 1, 'h00, 0, 0, 0, "R8 hi disable");
        cyc(1, 0, 0, 'h20, 0, 0, 0, "R8 reload drop");
        cyc(1, 0, 1, 'h08, 0, 0, 0, "R7 hi en2");
        cyc(1, 0, 0, 'h30, 0, 0, 1, "R8 write beats ack");
        cyc(0, 0, 0, 0, 0, 0, 0, "R8 still armed");
        // R10 write beats strobe
        cyc(1, 0, 1, 'h01, 0, 0, 0, "R10 hi");
        cyc(1, 0, 0, 'h40, 0, 1, 0, "R10 write vs strobe");
        cyc(0, 0, 0, 0, 0, 0, 0, "R10 settle");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule